// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Capture

This block turns a two-phase incremental encoder into position and speed samples. A position channel decodes the two phase inputs into a 16-bit up/down count. It counts on every edge of either phase, so it makes four counts per encoder line. A timebase channel advances once every `PRESC` system clocks. It raises two periodic events: a speed event when it equals a speed compare value, and a period event when it equals a period compare value. The period event also returns the timebase to zero.

Each event latches the position count into its own capture register. Every decoded count step latches the timebase count into a width register, and the old width first moves into a one-deep buffer. Software reads the time between encoder counts from the width pair. It reads the count per control period from the two position captures.

A flat register port gives access to the state: a write strobe, a read strobe, a 3-bit address and 16-bit data. Each capture register has a valid flag. The flag sets on capture and clears when the register is read.

Top module: `qenc_capture`

## Requirements
- R1: Each phase input passes through a two-flop synchronizer. A single edge on phase A or phase B when A leads B (sequence AB = 00, 10, 11, 01, 00) adds one to the position count. The new count appears at the third rising clock after the input changes.
- R2: A single edge when B leads A (sequence AB = 00, 01, 11, 10, 00) subtracts one from the position count.
- R3: When both phases change in the same cycle, the count does not change. Later single edges still count from the new phase state.
- R4: The position count wraps modulo 65536 in both directions. A wrap sets the sticky output `pos_wrap_o`. A write to address 0 (position count) loads the count and clears `pos_wrap_o`.
- R5: The timebase (address 1) advances by one every `PRESC` (default 4) clocks. When it equals the period compare (address 3), it returns to 0 on its next advance. A write to address 1 loads the count and restarts the prescaler. After such a write at clock edge W, the count at edge W+k is floor(k/4) mod (period+1).
- R6: When the timebase equals the speed compare (address 2) on an advance, the position count is copied into the speed capture (address 4). The timebase is not cleared.
- R7: When the timebase equals the period compare on an advance, the position count is copied into the position capture (address 5).
- R8: Each decoded count step copies the timebase count into the width capture (address 6). The previous width capture moves into the width buffer (address 7) at the same time.
- R9: `cap_valid_o` bits 0 to 3 belong to addresses 4 to 7. A bit sets when its register captures and clears when that register is read with `rd_i`. A capture in the same cycle as the read wins.
- R10: The capture registers can be written. When a write and a hardware capture hit the same register in the same cycle, the capture value is stored.
- R11: After reset, both counts and all captures are 0, both compares are 0xFFFF, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pha_i | input | 1 | Encoder phase A (asynchronous) |
| phb_i | input | 1 | Encoder phase B (asynchronous) |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (clears the capture valid flag) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| cap_valid_o | output | 4 | Valid flags for the captures at addresses 4..7 |
| pos_wrap_o | output | 1 | Sticky position wrap flag |

## Verification
An encoder edge reaches the position count and the width capture at the third rising edge after the input changes. The bench therefore holds each phase state for four clocks before it moves again. Width values are fixed by the step edge at k+3 after a timebase write at edge 0, where the capture holds floor((k+2)/4). Compare events fall at the advance edge, which is edge 4·(compare+1) for the period event. The forced collision writes are placed so that their write edge is exactly that edge. Timebase samples are taken directly at k = 3, 4, 39 and 40 after a load. All other results are queued as expected register, flag or wrap values and compared only after the stimulus has settled.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CAP = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_POS     = 3'd0,
    A_TB      = 3'd1,
    A_CMP_SPD = 3'd2,
    A_CMP_PER = 3'd3,
    A_CAP_SPD = 3'd4,
    A_CAP_POS = 3'd5,
    A_WID     = 3'd6,
    A_WID_BUF = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/qenc_decoder.sv
module qenc_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pha_i,
  input  logic phb_i,
  output logic step_o,
  output logic up_o
);
  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic a_q, b_q;
  logic a_now, b_now, edge_a, edge_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_a <= '0;
      sync_b <= '0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], pha_i};
      sync_b <= {sync_b[SYNC_STAGES-2:0], phb_i};
      a_q    <= a_now;
      b_q    <= b_now;
    end
  end

  assign a_now  = sync_a[SYNC_STAGES-1];
  assign b_now  = sync_b[SYNC_STAGES-1];
  assign edge_a = a_now ^ a_q;
  assign edge_b = b_now ^ b_q;

  // exactly one phase moved: a valid quadrature step
  assign step_o = edge_a ^ edge_b;
  assign up_o   = edge_a ? (a_now != b_now) : (a_now == b_now);

  // R3: a simultaneous change never leaves the phase pair looking like a single step
  p_no_step_on_double_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_a && edge_b) |=> (a_q != $past(a_q)) && (b_q != $past(b_q)));
endmodule

// File: rtl/qenc_pos_chan.sv
module qenc_pos_chan #(
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  step_i,
  input  logic                  up_i,
  input  logic                  wr_cnt_i,
  input  logic [CNT_W-1:0]      wdata_i,
  input  logic [1:0]            cap_evt_i,
  input  logic [1:0]            cap_wr_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [1:0][CNT_W-1:0] cap_o,
  output logic                  wrap_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else if (wr_cnt_i) begin
      cnt_o  <= wdata_i;
      wrap_o <= 1'b0;
    end else if (step_i) begin
      cnt_o <= up_i ? cnt_o + ONE : cnt_o - ONE;
      if ((up_i && cnt_o == MAX_V) || (!up_i && cnt_o == '0)) wrap_o <= 1'b1;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cap_o[i] <= '0;
      else if (cap_evt_i[i]) cap_o[i] <= cnt_o;   // capture beats write
      else if (cap_wr_i[i])  cap_o[i] <= wdata_i;
    end
  end

  p_up_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && step_i && up_i) |=> cnt_o == $past(cnt_o) + ONE);
  p_down_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && step_i && !up_i) |=> cnt_o == $past(cnt_o) - ONE);
  p_hold_no_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && !step_i) |=> $stable(cnt_o));
  p_wrap_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && step_i && up_i && cnt_o == MAX_V) |=> wrap_o && cnt_o == '0);
  p_spd_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i[0] |=> cap_o[0] == $past(cnt_o));
  p_cap_beats_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i[1] && cap_wr_i[1]) |=> cap_o[1] == $past(cnt_o));
endmodule

// File: rtl/qenc_timebase.sv
module qenc_timebase #(
  parameter int CNT_W = 16,
  parameter int PRESC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cnt_i,
  input  logic             wr_cmp_spd_i,
  input  logic             wr_cmp_per_i,
  input  logic             wr_wid_i,
  input  logic             wr_wid_buf_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_spd_o,
  output logic [CNT_W-1:0] cmp_per_o,
  output logic             match_spd_o,
  output logic             match_per_o,
  output logic [CNT_W-1:0] wid_o,
  output logic [CNT_W-1:0] wid_buf_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic tick;

  if (PRESC == 1) begin : g_nodiv
    assign tick = 1'b1;
  end else begin : g_div
    logic [PW-1:0] pre_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        pre_q <= '0;
      else if (wr_cnt_i)                  pre_q <= '0;
      else if (pre_q == PW'(PRESC - 1))   pre_q <= '0;
      else                                pre_q <= pre_q + PW'(1);
    end
    assign tick = (pre_q == PW'(PRESC - 1));
  end

  assign match_per_o = tick && !wr_cnt_i && (cnt_o == cmp_per_o);
  assign match_spd_o = tick && !wr_cnt_i && (cnt_o == cmp_spd_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (wr_cnt_i)    cnt_o <= wdata_i;
    else if (match_per_o) cnt_o <= '0;
    else if (tick)        cnt_o <= cnt_o + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_spd_o <= '1;
      cmp_per_o <= '1;
    end else begin
      if (wr_cmp_spd_i) cmp_spd_o <= wdata_i;
      if (wr_cmp_per_i) cmp_per_o <= wdata_i;
    end
  end

  // width capture with one-deep buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_o     <= '0;
      wid_buf_o <= '0;
    end else if (pulse_i) begin
      wid_o     <= cnt_o;
      wid_buf_o <= wid_o;
    end else begin
      if (wr_wid_i)     wid_o     <= wdata_i;
      if (wr_wid_buf_i) wid_buf_o <= wdata_i;
    end
  end

  p_period_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_per_o |=> cnt_o == '0);
  p_hold_between_ticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !wr_cnt_i) |=> $stable(cnt_o));
  p_width_buffer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (wid_o == $past(cnt_o)) && (wid_buf_o == $past(wid_o)));
endmodule

// File: rtl/qenc_capture.sv
module qenc_capture
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pha_i,
  input  logic               phb_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic [NUM_CAP-1:0] cap_valid_o,
  output logic               pos_wrap_o
);
  logic step, up;
  logic match_spd, match_per;
  logic [CNT_W-1:0] pos_cnt, tb_cnt, cmp_spd, cmp_per, wid, wid_buf;
  logic [1:0][CNT_W-1:0] pos_cap;
  logic [NUM_CAP-1:0] cap_set, cap_clr;

  qenc_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pha_i (pha_i),
    .phb_i (phb_i),
    .step_o(step),
    .up_o  (up)
  );

  qenc_pos_chan #(.CNT_W(CNT_W)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .up_i     (up),
    .wr_cnt_i (wr_i && addr_i == A_POS),
    .wdata_i  (wdata_i),
    .cap_evt_i({match_per, match_spd}),
    .cap_wr_i ({wr_i && addr_i == A_CAP_POS, wr_i && addr_i == A_CAP_SPD}),
    .cnt_o    (pos_cnt),
    .cap_o    (pos_cap),
    .wrap_o   (pos_wrap_o)
  );

  qenc_timebase #(.CNT_W(CNT_W), .PRESC(PRESC)) u_tb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_cnt_i    (wr_i && addr_i == A_TB),
    .wr_cmp_spd_i(wr_i && addr_i == A_CMP_SPD),
    .wr_cmp_per_i(wr_i && addr_i == A_CMP_PER),
    .wr_wid_i    (wr_i && addr_i == A_WID),
    .wr_wid_buf_i(wr_i && addr_i == A_WID_BUF),
    .wdata_i     (wdata_i),
    .pulse_i     (step),
    .cnt_o       (tb_cnt),
    .cmp_spd_o   (cmp_spd),
    .cmp_per_o   (cmp_per),
    .match_spd_o (match_spd),
    .match_per_o (match_per),
    .wid_o       (wid),
    .wid_buf_o   (wid_buf)
  );

  always_comb begin
    unique case (addr_i)
      A_POS:     rdata_o = pos_cnt;
      A_TB:      rdata_o = tb_cnt;
      A_CMP_SPD: rdata_o = cmp_spd;
      A_CMP_PER: rdata_o = cmp_per;
      A_CAP_SPD: rdata_o = pos_cap[0];
      A_CAP_POS: rdata_o = pos_cap[1];
      A_WID:     rdata_o = wid;
      default:   rdata_o = wid_buf;
    endcase
  end

  assign cap_set = {step, step, match_per, match_spd};

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_valid
    assign cap_clr[i] = rd_i && (addr_i == ADDR_W'(4 + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cap_valid_o[i] <= 1'b0;
      else if (cap_set[i]) cap_valid_o[i] <= 1'b1;   // set beats read
      else if (cap_clr[i]) cap_valid_o[i] <= 1'b0;
    end
  end

  p_valid_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_per |=> cap_valid_o[1]);
  p_valid_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_CAP_SPD && !match_spd) |=> !cap_valid_o[0]);
  p_width_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> cap_valid_o[2] && cap_valid_o[3]);
endmodule

// File: tb/sim_qenc_capture.sv
`timescale 1ns/1ps
module sim_qenc_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pha = 1'b0, phb = 1'b0;
  logic drv_wr = 1'b0, drv_rd = 1'b0, mon_rd = 1'b0;
  logic [2:0] drv_addr = 3'd0, mon_addr = 3'd0;
  logic [15:0] drv_wdata = 16'h0;
  logic [15:0] rdata;
  logic [3:0] cap_valid;
  logic pos_wrap;
  logic rd_en;
  logic [2:0] addr;

  int n_chk = 0, n_fail = 0, idx = 0;

  typedef struct {
    int          kind;   // 0 register, 1 valid flags, 2 wrap flag
    logic [2:0]  addr;
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  assign rd_en = mon_rd | drv_rd;
  assign addr  = mon_rd ? mon_addr : drv_addr;

  qenc_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .pha_i(pha), .phb_i(phb),
    .wr_i(drv_wr), .rd_i(rd_en), .addr_i(addr), .wdata_i(drv_wdata),
    .rdata_o(rdata), .cap_valid_o(cap_valid), .pos_wrap_o(pos_wrap)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [15:0] v, input string tag);
    item_t it;
    it.kind = 0; it.addr = a; it.exp = v; it.mask = 16'hFFFF; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_flags(input logic [3:0] m, input logic [3:0] v, input string tag);
    item_t it;
    it.kind = 1; it.addr = 3'd0; it.exp = {12'h0, v}; it.mask = {12'h0, m}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_wrap(input logic v, input string tag);
    item_t it;
    it.kind = 2; it.addr = 3'd0; it.exp = {15'h0, v}; it.mask = 16'h1; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        if (it.kind == 0) begin
          mon_addr = it.addr;
          mon_rd = 1'b1;
          #1 got = rdata;
        end else if (it.kind == 1) begin
          got = {12'h0, cap_valid} & it.mask;
        end else begin
          got = {15'h0, pos_wrap};
        end
        check(got, it.exp, it.tag);
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    drv_addr = a; drv_wdata = d; drv_wr = 1'b1;
    @(negedge clk);
    drv_wr = 1'b0;
  endtask

  function automatic logic [1:0] phase_of(input int i);
    case (i % 4)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic set_step(input bit go_up);
    idx = go_up ? (idx + 1) % 4 : (idx + 3) % 4;
    {pha, phb} = phase_of(idx);
  endtask

  task automatic mv(input bit go_up);
    set_step(go_up);
    wait_n(4);
  endtask

  task automatic peek(input logic [2:0] a, input logic [15:0] exp, input string tag);
    drv_addr = a;
    #1 check(rdata, exp, tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R11 reset state
    exp_reg(3'd0, 16'h0000, "R11 pos");
    exp_reg(3'd2, 16'hFFFF, "R11 cmp_spd");
    exp_reg(3'd3, 16'hFFFF, "R11 cmp_per");
    exp_flags(4'hF, 4'h0, "R11 valid");
    exp_wrap(1'b0, "R11 wrap");
    exp_reg(3'd6, 16'h0000, "R11 width");
    drain();

    // R1: two lines forward, A leads B
    for (int i = 0; i < 8; i++) mv(1'b1);
    exp_reg(3'd0, 16'd8, "R1 up count");
    exp_flags(4'hC, 4'hC, "R9 width valid set");
    drain();

    // R2: three edges backward
    for (int i = 0; i < 3; i++) mv(1'b0);
    exp_reg(3'd0, 16'd5, "R2 down count");
    drain();

    // R3: both phases flip together
    {pha, phb} = ~{pha, phb};
    idx = (idx + 2) % 4;
    wait_n(6);
    exp_reg(3'd0, 16'd5, "R3 double edge ignored");
    drain();
    mv(1'b0);
    exp_reg(3'd0, 16'd4, "R3 step after double edge");
    drain();

    // R4: wrap down, clear on write, wrap up
    wr(3'd0, 16'd1);
    mv(1'b0);
    mv(1'b0);
    exp_reg(3'd0, 16'hFFFF, "R4 wrap down value");
    exp_wrap(1'b1, "R4 wrap down flag");
    drain();
    wr(3'd0, 16'hFFFD);
    exp_wrap(1'b0, "R4 write clears wrap");
    drain();
    for (int i = 0; i < 3; i++) mv(1'b1);
    exp_reg(3'd0, 16'h0000, "R4 wrap up value");
    exp_wrap(1'b1, "R4 wrap up flag");
    drain();

    // R5..R7: timebase period and event captures
    wr(3'd3, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'd0);                 // k = 0
    wait_n(3);  peek(3'd1, 16'd0, "R5 tb k=3");
    wait_n(1);  peek(3'd1, 16'd1, "R5 tb k=4");
    wait_n(35); peek(3'd1, 16'd9, "R5 tb k=39");
    wait_n(1);  peek(3'd1, 16'd0, "R5 tb k=40 cleared");
    exp_flags(4'h3, 4'h3, "R9 event valid set");
    exp_reg(3'd4, 16'h1234, "R6 speed capture");
    exp_reg(3'd5, 16'h1234, "R7 position capture");
    exp_flags(4'h1, 4'h0, "R9 read clears valid");
    drain();
    wait_n(60);
    exp_flags(4'h3, 4'h3, "R9 valid set again");
    drain();

    // R8: width capture and buffer
    wr(3'd3, 16'hFFFF);
    wr(3'd1, 16'd0);                 // k = 0
    wait_n(20);
    set_step(1'b1);                  // captured at edge 23 -> 5
    wait_n(20);
    set_step(1'b1);                  // captured at edge 43 -> 10
    wait_n(10);
    exp_reg(3'd6, 16'd10, "R8 width");
    exp_reg(3'd7, 16'd5, "R8 width buffer");
    exp_reg(3'd0, 16'h1236, "R1 count after width steps");
    drain();

    // R10: plain write, then write colliding with period capture
    wr(3'd3, 16'd9);
    wr(3'd1, 16'd0);                 // k = 0
    wait_n(20);
    wr(3'd5, 16'hBEEF);              // write edge 22, k = 22 after
    peek(3'd5, 16'hBEEF, "R10 capture reg write");
    wait_n(16);                      // k = 38
    wr(3'd5, 16'hCAFE);              // write edge 40 = period event
    exp_reg(3'd5, 16'h1236, "R10 capture beats write");
    drain();

    report();
  end
endmodule